// File: doc/BRIEF.md
# Host Memory-Window Address Decoder

This block places a 128-byte peripheral window in a 1 MB host memory space and decodes host memory reads and writes that fall inside it. An 8-bit switch value picks one of 256 4 KB regions. The window always occupies the top 128 bytes of that region, at offsets F80 to FFF. Inside the window, two address bits split the space into three areas: a command area for a backplane of plug-in modules, the registers of an interval timer, and four timer-support registers. Each area gets its own active-low enable.

The support area is decoded further into four read strobes and four write strobes, one of each per register. The backplane select is asserted at once for a read. For a write it is asserted only after a fixed number of clock cycles, so that the backplane sees settled data. The block also drives the enable and direction of the data-bus buffers between host and backplane. While a DMA cycle owns the bus, the block does not respond at all.

Top module: `memwin_decode`

## Requirements
- R1: A cycle is in the window only when sys_addr[19:12] equals base_sel; any other value of those bits gives all enables, strobes and buf_oe_n high.
- R2: A cycle is in the window only when sys_addr[11:7] are all 1. If any of those bits is 0, all enables, strobes and buf_oe_n stay high.
- R3: While dma_active is 1, every active-low output stays high, whatever the address and strobes are.
- R4: Inside the window, sys_addr[6:5] picks the area. 00 drives bp_en_n low, 10 drives tmr_cs_n low and 11 enables the support area. 01 is reserved: it enables nothing and keeps buf_oe_n high.
- R5: In the support area, sys_addr[1:0] selects the register: 0 global, 1 status, 2 clear interrupt, 3 interrupt level. A read drives sup_rd_n[index] low and a write drives sup_wr_n[index] low. At most one of these eight bits is low, and sys_addr[4:2] has no effect on them.
- R6: The block responds only while a memory strobe is active. A read is mem_rd_n low. A write is mem_wr_n low with mem_rd_n high. When both strobes are high, every active-low output is high.
- R7: A read in the backplane area drives bp_sel_n low in the same cycle, without waiting for a clock edge.
- R8: A write in the backplane area holds bp_sel_n high until WR_DELAY rising clock edges have passed with the write continuously active. From then on bp_sel_n is low. It goes high as soon as the write ends, and a new write starts the count again from zero.
- R9: buf_oe_n is low for any enabled access in the backplane, timer or support area. buf_dir is 1 (toward the host) during a read and 0 otherwise.
- R10: During and right after reset, with no strobe active, every active-low output is high and buf_dir is 0. A write that is already active when reset is released must still wait the full WR_DELAY edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that times the write delay |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_addr | input | 20 | Host memory address |
| dma_active | input | 1 | High while a DMA cycle owns the bus |
| mem_rd_n | input | 1 | Active-low memory read strobe |
| mem_wr_n | input | 1 | Active-low memory write strobe |
| base_sel | input | 8 | Switch value that selects the 4 KB region |
| bp_en_n | output | 1 | Active-low enable for the backplane command area |
| tmr_cs_n | output | 1 | Active-low chip select for the interval timer |
| sup_rd_n | output | 4 | Active-low read strobes for the support registers |
| sup_wr_n | output | 4 | Active-low write strobes for the support registers |
| bp_sel_n | output | 1 | Active-low backplane select, delayed on writes |
| buf_oe_n | output | 1 | Active-low enable for the data-bus buffers |
| buf_dir | output | 1 | Buffer direction: 1 drives toward the host |

## Verification
The hardest behaviour to reach is the edge of the delayed write select. The bench must hold a backplane write through exactly WR_DELAY-1 and then WR_DELAY clock edges, and it must also break a write off early and start it again to show that the count restarts. The driver therefore holds the same write inputs across a chosen number of edges. The bench keeps its own count of continuous write edges, and the monitor compares bp_sel_n against that count after every edge. A write that is active when reset is released is also driven, to show that the count starts from zero.

// File: rtl/memwin_decode.sv
module memwin_decode #(
  parameter int WR_DELAY = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] sys_addr,
  input  logic        dma_active,
  input  logic        mem_rd_n,
  input  logic        mem_wr_n,
  input  logic [7:0]  base_sel,
  output logic        bp_en_n,
  output logic        tmr_cs_n,
  output logic [3:0]  sup_rd_n,
  output logic [3:0]  sup_wr_n,
  output logic        bp_sel_n,
  output logic        buf_oe_n,
  output logic        buf_dir
);
  localparam int CW = $clog2(WR_DELAY + 1);
  localparam logic [CW-1:0] DLY = CW'(WR_DELAY);

  logic rd_act, wr_act, acc, hit;
  logic in_bp, in_tmr, in_sup;
  logic bp_wr, wr_ready;
  logic [CW-1:0] wcnt;

  assign rd_act = ~mem_rd_n;
  assign wr_act = ~mem_wr_n & mem_rd_n;
  assign acc    = rd_act | wr_act;

  assign hit = ~dma_active & (sys_addr[19:12] == base_sel) & (&sys_addr[11:7]) & acc;

  assign in_bp  = hit & (sys_addr[6:5] == 2'b00);
  assign in_tmr = hit & (sys_addr[6:5] == 2'b10);
  assign in_sup = hit & (sys_addr[6:5] == 2'b11);

  assign bp_en_n  = ~in_bp;
  assign tmr_cs_n = ~in_tmr;

  for (genvar i = 0; i < 4; i++) begin : g_sup
    assign sup_rd_n[i] = ~(in_sup & rd_act & (sys_addr[1:0] == 2'(i)));
    assign sup_wr_n[i] = ~(in_sup & wr_act & (sys_addr[1:0] == 2'(i)));
  end

  assign bp_wr = in_bp & wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wcnt <= '0;
    else if (!bp_wr)
      wcnt <= '0;
    else if (wcnt != DLY)
      wcnt <= wcnt + 1'b1;
  end

  assign wr_ready = (wcnt == DLY);
  assign bp_sel_n = ~((in_bp & rd_act) | (bp_wr & wr_ready));

  assign buf_oe_n = ~(in_bp | in_tmr | in_sup);
  assign buf_dir  = rd_act;
endmodule

module memwin_decode_chk #(
  parameter int WR_DELAY = 25
) (
  input logic        clk,
  input logic        rst_n,
  input logic [19:0] sys_addr,
  input logic        dma_active,
  input logic        mem_rd_n,
  input logic        mem_wr_n,
  input logic        bp_en_n,
  input logic        tmr_cs_n,
  input logic [3:0]  sup_rd_n,
  input logic [3:0]  sup_wr_n,
  input logic        bp_sel_n,
  input logic        buf_oe_n
);
  logic all_off, wr_on_bp, sup_on;
  int   wc;

  assign all_off  = &{bp_en_n, tmr_cs_n, sup_rd_n, sup_wr_n, bp_sel_n, buf_oe_n};
  assign wr_on_bp = !bp_en_n && !mem_wr_n && mem_rd_n;
  assign sup_on   = !(&{sup_rd_n, sup_wr_n});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wc <= 0;
    else if (!wr_on_bp)     wc <= 0;
    else if (wc < WR_DELAY) wc <= wc + 1;
  end

  p_dma_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> all_off);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_n && mem_wr_n) |-> all_off);
  p_window_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&sys_addr[11:7]) |-> buf_oe_n);
  p_area_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!bp_en_n, !tmr_cs_n, sup_on}));
  p_sup_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{sup_rd_n, sup_wr_n}));
  p_rd_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_en_n && !mem_rd_n) |-> !bp_sel_n);
  p_wr_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on_bp && wc < WR_DELAY) |-> bp_sel_n);
  p_wr_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_on_bp && wc == WR_DELAY) |-> !bp_sel_n);
  p_buf_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_en_n || !tmr_cs_n || sup_on) |-> !buf_oe_n);
endmodule

bind memwin_decode memwin_decode_chk #(.WR_DELAY(WR_DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .dma_active(dma_active),
  .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .bp_en_n(bp_en_n),
  .tmr_cs_n(tmr_cs_n), .sup_rd_n(sup_rd_n), .sup_wr_n(sup_wr_n),
  .bp_sel_n(bp_sel_n), .buf_oe_n(buf_oe_n)
);

// File: tb/tb_memwin_decode.sv
module tb_memwin_decode;
  localparam int D = 5;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [19:0] sys_addr = '0;
  logic        dma_active = 0;
  logic        mem_rd_n = 1;
  logic        mem_wr_n = 1;
  logic [7:0]  base_sel = 8'hCF;
  logic        bp_en_n, tmr_cs_n, bp_sel_n, buf_oe_n, buf_dir;
  logic [3:0]  sup_rd_n, sup_wr_n;

  memwin_decode #(.WR_DELAY(D)) dut (
    .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .dma_active(dma_active),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .base_sel(base_sel),
    .bp_en_n(bp_en_n), .tmr_cs_n(tmr_cs_n), .sup_rd_n(sup_rd_n),
    .sup_wr_n(sup_wr_n), .bp_sel_n(bp_sel_n), .buf_oe_n(buf_oe_n),
    .buf_dir(buf_dir)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, wedges = 0;
  logic [12:0] q_exp[$];
  string       q_tag[$];
  event        chk_ev;
  bit          done = 0;

  function automatic logic bp_write_now();
    return !dma_active && sys_addr[19:12] == base_sel && (&sys_addr[11:7])
           && sys_addr[6:5] == 2'b00 && !mem_wr_n && mem_rd_n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !bp_write_now()) wedges <= 0;
    else wedges <= wedges + 1;
  end

  function automatic logic [12:0] model();
    logic rd, wr, win, bp, tm, su, sel;
    logic [3:0] sr, sw;
    rd  = !mem_rd_n;
    wr  = !mem_wr_n && mem_rd_n;
    win = !dma_active && sys_addr[19:12] == base_sel && (&sys_addr[11:7]) && (rd || wr);
    bp  = win && sys_addr[6:5] == 2'b00;
    tm  = win && sys_addr[6:5] == 2'b10;
    su  = win && sys_addr[6:5] == 2'b11;
    sr  = 4'hF; sw = 4'hF;
    if (su && rd) sr[sys_addr[1:0]] = 1'b0;
    if (su && wr) sw[sys_addr[1:0]] = 1'b0;
    sel = bp && (rd || (wr && wedges >= D));
    return {!bp, !tm, sr, sw, !sel, !(bp || tm || su), rd};
  endfunction

  task automatic push(string tag);
    #1;
    q_exp.push_back(model());
    q_tag.push_back(tag);
    ->chk_ev;
    #1;
  endtask

  task automatic drive(logic [19:0] a, logic [7:0] b, logic dma, logic rd, logic wr, string tag);
    @(negedge clk);
    sys_addr = a; base_sel = b; dma_active = dma; mem_rd_n = rd; mem_wr_n = wr;
    push(tag);
  endtask

  task automatic hold(string tag);
    @(negedge clk);
    push(tag);
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q_exp.size() > 0) begin
        logic [12:0] e, a;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = {bp_en_n, tmr_cs_n, sup_rd_n, sup_wr_n, bp_sel_n, buf_oe_n, buf_dir};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state, idle strobes
    @(negedge clk); push("R10 in reset");
    // R10 write active across reset release must still wait full delay
    sys_addr = 20'hCFF80; mem_wr_n = 0;
    @(negedge clk); push("R10 write held in reset");
    rst_n = 1;
    for (int k = 1; k < D; k++) hold("R10 delay after reset");
    hold("R10 delay reached after reset");
    drive(20'hCFF80, 8'hCF, 0, 1, 1, "R10 idle after reset");
    drive(20'hCFF80, 8'hCF, 0, 1, 1, "R6 idle strobes");
    drive(20'hCFF80, 8'hCF, 0, 0, 1, "R7 backplane read immediate");
    drive(20'hCFF85, 8'hCF, 0, 0, 0, "R6 both strobes low counts as read");
    drive(20'hCEF80, 8'hCF, 0, 0, 1, "R1 base mismatch");
    drive(20'h5AFE0, 8'h5A, 0, 0, 1, "R1 other base global read");
    drive(20'hCFF00, 8'hCF, 0, 0, 1, "R2 bit7 low");
    drive(20'hCF780, 8'hCF, 0, 1, 0, "R2 bit11 low");
    drive(20'hCFF80, 8'hCF, 1, 0, 1, "R3 dma read");
    drive(20'hCFFE2, 8'hCF, 1, 1, 0, "R3 dma support write");
    drive(20'hCFFC1, 8'hCF, 0, 1, 0, "R4 timer write");
    drive(20'hCFFC3, 8'hCF, 0, 0, 1, "R9 timer read direction");
    drive(20'hCFFA0, 8'hCF, 0, 0, 1, "R4 reserved read");
    drive(20'hCFFA0, 8'hCF, 0, 1, 0, "R4 reserved write");
    drive(20'hCFFE1, 8'hCF, 0, 0, 1, "R5 status read");
    drive(20'hCFFE2, 8'hCF, 0, 1, 0, "R5 clear write");
    drive(20'hCFFFF, 8'hCF, 0, 1, 0, "R5 level write bits4to2 ignored");
    drive(20'hCFFE0, 8'hCF, 0, 1, 0, "R5 global write");
    drive(20'hCFFFC, 8'hCF, 0, 0, 1, "R5 global read alias");
    // R8 delayed write
    drive(20'hCFF90, 8'hCF, 0, 1, 0, "R8 write start held off");
    for (int k = 1; k < D; k++) hold("R8 before delay");
    hold("R8 at delay");
    hold("R8 after delay");
    hold("R9 write direction");
    drive(20'hCFF90, 8'hCF, 0, 1, 1, "R8 release immediate");
    drive(20'hCFF90, 8'hCF, 0, 1, 0, "R8 restart");
    hold("R8 restart partial");
    drive(20'hCFF90, 8'hCF, 0, 1, 1, "R8 broken off");
    drive(20'hCFF90, 8'hCF, 0, 1, 0, "R8 count restarts");
    for (int k = 1; k < D; k++) hold("R8 restarted still off");
    hold("R8 restarted reaches delay");
    drive(20'hCFF80, 8'hCF, 0, 1, 1, "R6 back to idle");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule